// File: doc/BRIEF.md
# Receive Address Filter and Packet Ring Writer

This block sits between a receive MAC and the on-chip packet memory of a network controller. A frame is announced by a one-cycle start strobe that carries its byte length and the CRC32 of its destination address, which is computed upstream. The frame bytes then follow on a valid/ready byte stream. The block holds back the six destination bytes and decides from the receive configuration whether the frame is wanted. It accepts promiscuous traffic, broadcast, multicast looked up in a 64-entry hash table, or a unicast address that matches the station address.

An accepted frame is written into a circular buffer made of 256-byte pages. The buffer lies between a start page and a stop page. Writes go one byte per cycle through a simple synchronous write port. Each frame begins on the current page with a four-byte header, and the data follows the header. The data wraps from the stop address back to the start address. When the last byte has been written, the current-page pointer moves to the page after the frame, and a one-cycle completion pulse goes to the interrupt unit. A frame is refused as a whole, with nothing written, when the controller is halted or when the free space up to the boundary page cannot hold a maximum frame.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame that starts while `rx_halt` is high is consumed from the stream. It produces no memory write and no `rx_done`, and `busy` stays low.
- R2: A frame is refused in the same way when the ring is full. The ring is full if `page_stop` <= `page_start`. It is also full if the free space is below 1518 bytes, where free space is 256*(bound-cur) when cur < bound, and otherwise 256*(stop-start) - 256*(cur-bound).
- R3: With `rx_cfg` bit 4 set, every frame is accepted whatever its destination.
- R4: A destination of six 0xFF bytes is accepted only when `rx_cfg` bit 2 is set. This is checked before the multicast rule.
- R5: Any other destination whose first byte has bit 0 set is accepted only when `rx_cfg` bit 3 is set and `mcast_table[frm_crc[31:26]]` is 1. Bit n of the table is bit n%8 of hash byte n/8.
- R6: A destination with first-byte bit 0 clear is accepted only when all six bytes equal `station_addr`. `station_addr[7:0]` is compared with the first destination byte.
- R7: An accepted frame gets a four-byte header at address cur_page*256. The header bytes are: status, next page, total length low byte, total length high byte. The total length is the stored length plus 4.
- R8: A frame shorter than 60 bytes is stored as 60 bytes, with zeros after its last byte.
- R9: The next page is cur + ceil((total+4)/256). When that value is not below `page_stop`, (stop-start) is subtracted from it.
- R10: Frame data starts at header address + 4. When the write address reaches stop*256, it continues at start*256.
- R11: The status byte is 0x01, with bit 5 also set when destination bit 0 is set. `rx_status` holds the status of the last accepted frame.
- R12: After the last data byte, `cur_page` takes the next page and `rx_done` pulses for exactly one cycle.
- R13: `busy` is high from the cycle after an accepted frame start until its last header byte has been written. `rx_done` is never high while `busy` is high.
- R14: A `cur_load` strobe copies `cur_load_page` into `cur_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_halt | input | 1 | Controller halted; incoming frames are refused |
| rx_cfg | input | 8 | Receive configuration (bit 2 broadcast, bit 3 multicast, bit 4 promiscuous) |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| mcast_table | input | 64 | Multicast hash table |
| page_start | input | 8 | First page of the ring |
| page_stop | input | 8 | Page after the last ring page |
| page_bound | input | 8 | Boundary page, the oldest page not yet released |
| cur_load | input | 1 | Load strobe for the current page |
| cur_load_page | input | 8 | Value for the current page |
| frm_start | input | 1 | Frame start strobe, taken when idle |
| frm_len | input | 11 | Frame length in bytes, at least 6 |
| frm_crc | input | 32 | CRC32 of the destination address |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| busy | output | 1 | Frame admitted, header not yet committed |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | 8 | Current receive page |
| rx_status | output | 8 | Status of the last accepted frame |
| rx_done | output | 1 | One-cycle frame-stored pulse |

## Verification
The hardest conditions to reach are the free-space edge just below and just above 1518 bytes, and a frame whose data runs over the stop page. Neither happens with a freshly reset ring. The bench therefore uses `cur_load` and `page_bound` to place the current page and the boundary before each of these frames. It sets a gap of five and then six pages for the space edge. For the wrap it sets the current page to the last ring page, and the other side of the space formula is reached with the current page above the boundary. For the next-page rounding, lengths of 248 and 249 bytes are used, which land exactly on and one past a page edge.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  parameter int PG_W     = 8;
  parameter int LEN_W    = 11;
  parameter int ADDR_W   = PG_W + 8;
  parameter int TOT_W    = 16;
  parameter int HASH_W   = 6;
  parameter int MIN_FRM  = 60;
  parameter int MIN_FREE = 1518;
  parameter int HDR_LEN  = 4;
  parameter int DST_LEN  = 6;

  parameter int CFG_BCAST   = 2;
  parameter int CFG_MCAST   = 3;
  parameter int CFG_PROMISC = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CHECK, S_HDR, S_DST, S_BODY, S_PAD, S_FIN, S_DROP
  } rxr_state_e;

  // ring full when stop not above start, or free bytes below one max frame
  function automatic logic f_ring_full(input logic [PG_W-1:0] cur,
                                       input logic [PG_W-1:0] bnd,
                                       input logic [PG_W-1:0] start,
                                       input logic [PG_W-1:0] stop);
    int cur_a, bnd_a, ring, free;
    if (stop <= start) return 1'b1;
    cur_a = int'(cur) * 256;
    bnd_a = int'(bnd) * 256;
    ring  = (int'(stop) - int'(start)) * 256;
    if (cur < bnd) free = bnd_a - cur_a;
    else           free = ring - (cur_a - bnd_a);
    return (free < MIN_FREE);
  endfunction

  function automatic logic [PG_W-1:0] f_next_page(input logic [PG_W-1:0] cur,
                                                 input logic [PG_W-1:0] start,
                                                 input logic [PG_W-1:0] stop,
                                                 input logic [TOT_W-1:0] total);
    int n;
    n = int'(cur) + ((int'(total) + HDR_LEN + 255) / 256);
    if (n >= int'(stop)) n = n - (int'(stop) - int'(start));
    return PG_W'(n);
  endfunction

  function automatic logic [ADDR_W-1:0] f_step(input logic [ADDR_W-1:0] addr,
                                              input logic [PG_W-1:0] start,
                                              input logic [PG_W-1:0] stop);
    logic [ADDR_W-1:0] nx;
    nx = addr + ADDR_W'(1);
    if (nx == {stop, 8'h00}) nx = {start, 8'h00};
    return nx;
  endfunction

  function automatic logic [LEN_W-1:0] f_pad_len(input logic [LEN_W-1:0] len);
    return (len < LEN_W'(MIN_FRM)) ? LEN_W'(MIN_FRM) : len;
  endfunction
endpackage

// File: rtl/rxr_filter.sv
`timescale 1ns/1ps
module rxr_filter
  import rxr_pkg::*;
#(
  parameter int NBYTES = DST_LEN
) (
  input  logic [8*NBYTES-1:0] dst,
  input  logic [8*NBYTES-1:0] station,
  input  logic                promisc,
  input  logic                acc_bcast,
  input  logic                acc_mcast,
  input  logic [63:0]         mtable,
  input  logic [HASH_W-1:0]   hash_idx,
  output logic                accept,
  output logic                grp
);
  logic [NBYTES-1:0] byte_eq;
  logic              all_ones;
  logic              hash_hit;

  for (genvar g = 0; g < NBYTES; g++) begin : g_cmp
    assign byte_eq[g] = (dst[8*g +: 8] == station[8*g +: 8]);
  end

  assign all_ones = &dst;
  assign grp      = dst[0];
  assign hash_hit = mtable[hash_idx];

  always_comb begin
    if (promisc)       accept = 1'b1;
    else if (all_ones) accept = acc_bcast;
    else if (grp)      accept = acc_mcast & hash_hit;
    else               accept = &byte_eq;
  end
endmodule

// File: rtl/rxr_space.sv
`timescale 1ns/1ps
module rxr_space
  import rxr_pkg::*;
(
  input  logic [PG_W-1:0]  cur,
  input  logic [PG_W-1:0]  bnd,
  input  logic [PG_W-1:0]  start,
  input  logic [PG_W-1:0]  stop,
  input  logic [TOT_W-1:0] total,
  output logic             full,
  output logic [PG_W-1:0]  next_pg
);
  assign full    = f_ring_full(cur, bnd, start, stop);
  assign next_pg = f_next_page(cur, start, stop, total);
endmodule

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_halt,
  input  logic                 ring_full,
  input  logic                 filt_accept,
  input  logic                 filt_grp,
  input  logic [PG_W-1:0]      next_pg,
  input  logic [PG_W-1:0]      page_start,
  input  logic [PG_W-1:0]      page_stop,
  input  logic                 cur_load,
  input  logic [PG_W-1:0]      cur_load_page,
  input  logic                 frm_start,
  input  logic [LEN_W-1:0]     frm_len,
  input  logic [HASH_W-1:0]    frm_hash,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  output logic [8*DST_LEN-1:0] dst_q,
  output logic [HASH_W-1:0]    hash_q,
  output logic [TOT_W-1:0]     total_q,
  output logic [PG_W-1:0]      cur_page,
  output logic [PG_W-1:0]      next_q,
  output logic                 busy,
  output logic                 st_idle,
  output logic                 hdr_commit,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [7:0]           mem_wdata,
  output logic [7:0]           rx_status,
  output logic                 rx_done
);
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] DST_LAST = CNT_W'(DST_LEN - 1);

  rxr_state_e          st;
  logic [LEN_W-1:0]    flen, plen, wcnt, rem;
  logic [CNT_W-1:0]    acnt;
  logic [1:0]          hcnt;
  logic [PG_W-1:0]     base_pg;
  logic [ADDR_W-1:0]   wptr;
  logic [7:0]          stat_q;
  logic                beat;
  logic [7:0]          hdr_byte;

  assign st_idle    = (st == S_IDLE);
  assign busy       = (st == S_ADDR) || (st == S_CHECK) || (st == S_HDR);
  assign hdr_commit = (st == S_HDR) && (hcnt == 2'd3);
  assign rx_done    = (st == S_FIN);

  always_comb begin
    case (st)
      S_ADDR:  in_ready = 1'b1;
      S_BODY:  in_ready = (wcnt < flen);
      S_DROP:  in_ready = (rem != '0);
      default: in_ready = 1'b0;
    endcase
  end
  assign beat = in_valid & in_ready;

  always_comb begin
    case (hcnt)
      2'd0:    hdr_byte = stat_q;
      2'd1:    hdr_byte = next_q;
      2'd2:    hdr_byte = total_q[7:0];
      default: hdr_byte = total_q[15:8];
    endcase
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = wptr;
    mem_wdata = 8'h00;
    case (st)
      S_HDR: begin
        mem_we    = 1'b1;
        mem_addr  = {base_pg, 6'd0, hcnt};
        mem_wdata = hdr_byte;
      end
      S_DST: begin
        mem_we    = 1'b1;
        mem_wdata = dst_q[{acnt, 3'b000} +: 8];
      end
      S_BODY: begin
        mem_we    = beat;
        mem_wdata = in_data;
      end
      S_PAD: begin
        mem_we    = (wcnt < plen);
        mem_wdata = 8'h00;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      flen      <= '0;
      plen      <= '0;
      wcnt      <= '0;
      rem       <= '0;
      acnt      <= '0;
      hcnt      <= '0;
      base_pg   <= '0;
      wptr      <= '0;
      stat_q    <= '0;
      dst_q     <= '0;
      hash_q    <= '0;
      total_q   <= '0;
      next_q    <= '0;
      cur_page  <= '0;
      rx_status <= '0;
    end else begin
      if (st == S_FIN)   cur_page <= next_q;
      else if (cur_load) cur_page <= cur_load_page;

      case (st)
        S_IDLE: if (frm_start) begin
          flen    <= frm_len;
          plen    <= f_pad_len(frm_len);
          total_q <= TOT_W'(f_pad_len(frm_len)) + TOT_W'(HDR_LEN);
          hash_q  <= frm_hash;
          base_pg <= cur_page;
          acnt    <= '0;
          if (rx_halt || ring_full) begin
            st  <= S_DROP;
            rem <= frm_len;
          end else begin
            st  <= S_ADDR;
          end
        end
        S_ADDR: if (beat) begin
          dst_q[{acnt, 3'b000} +: 8] <= in_data;
          if (acnt == DST_LAST) st <= S_CHECK;
          else                  acnt <= acnt + 1'b1;
        end
        S_CHECK: begin
          if (filt_accept) begin
            stat_q    <= {2'b00, filt_grp, 4'b0000, 1'b1};
            rx_status <= {2'b00, filt_grp, 4'b0000, 1'b1};
            next_q    <= next_pg;
            hcnt      <= '0;
            wptr      <= {base_pg, 8'd4};
            st        <= S_HDR;
          end else begin
            rem <= flen - LEN_W'(DST_LEN);
            st  <= S_DROP;
          end
        end
        S_HDR: begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == 2'd3) begin
            acnt <= '0;
            st   <= S_DST;
          end
        end
        S_DST: begin
          wptr <= f_step(wptr, page_start, page_stop);
          if (acnt == DST_LAST) begin
            wcnt <= LEN_W'(DST_LEN);
            st   <= S_BODY;
          end else begin
            acnt <= acnt + 1'b1;
          end
        end
        S_BODY: begin
          if (wcnt >= flen) st <= S_PAD;
          else if (beat) begin
            wptr <= f_step(wptr, page_start, page_stop);
            wcnt <= wcnt + 1'b1;
          end
        end
        S_PAD: begin
          if (wcnt >= plen) st <= S_FIN;
          else begin
            wptr <= f_step(wptr, page_start, page_stop);
            wcnt <= wcnt + 1'b1;
          end
        end
        S_FIN: st <= S_IDLE;
        S_DROP: begin
          if (rem == '0) st <= S_IDLE;
          else if (beat) rem <= rem - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
`timescale 1ns/1ps
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int PAGE_W = PG_W,
  parameter int LENGTH_W = LEN_W,
  localparam int MADDR_W = PAGE_W + 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_halt,
  input  logic [7:0]          rx_cfg,
  input  logic [47:0]         station_addr,
  input  logic [63:0]         mcast_table,
  input  logic [PAGE_W-1:0]   page_start,
  input  logic [PAGE_W-1:0]   page_stop,
  input  logic [PAGE_W-1:0]   page_bound,
  input  logic                cur_load,
  input  logic [PAGE_W-1:0]   cur_load_page,
  input  logic                frm_start,
  input  logic [LENGTH_W-1:0] frm_len,
  input  logic [31:0]         frm_crc,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  output logic                in_ready,
  output logic                busy,
  output logic                mem_we,
  output logic [MADDR_W-1:0]  mem_addr,
  output logic [7:0]          mem_wdata,
  output logic [PAGE_W-1:0]   cur_page,
  output logic [7:0]          rx_status,
  output logic                rx_done
);
  logic [47:0]       dst_q;
  logic [HASH_W-1:0] hash_q;
  logic [TOT_W-1:0]  total_q;
  logic [PG_W-1:0]   next_pg, next_q;
  logic              ring_full, filt_accept, filt_grp;
  logic              st_idle, hdr_commit;
  logic              unused_bits;

  assign unused_bits = ^{frm_crc[31-HASH_W:0], rx_cfg[7:5], rx_cfg[1:0], hdr_commit};

  rxr_space u_space (
    .cur     (cur_page),
    .bnd     (page_bound),
    .start   (page_start),
    .stop    (page_stop),
    .total   (total_q),
    .full    (ring_full),
    .next_pg (next_pg)
  );

  rxr_filter #(.NBYTES(DST_LEN)) u_filter (
    .dst       (dst_q),
    .station   (station_addr),
    .promisc   (rx_cfg[CFG_PROMISC]),
    .acc_bcast (rx_cfg[CFG_BCAST]),
    .acc_mcast (rx_cfg[CFG_MCAST]),
    .mtable    (mcast_table),
    .hash_idx  (hash_q),
    .accept    (filt_accept),
    .grp       (filt_grp)
  );

  rxr_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_halt       (rx_halt),
    .ring_full     (ring_full),
    .filt_accept   (filt_accept),
    .filt_grp      (filt_grp),
    .next_pg       (next_pg),
    .page_start    (page_start),
    .page_stop     (page_stop),
    .cur_load      (cur_load),
    .cur_load_page (cur_load_page),
    .frm_start     (frm_start),
    .frm_len       (frm_len),
    .frm_hash      (frm_crc[31:32-HASH_W]),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .dst_q         (dst_q),
    .hash_q        (hash_q),
    .total_q       (total_q),
    .cur_page      (cur_page),
    .next_q        (next_q),
    .busy          (busy),
    .st_idle       (st_idle),
    .hdr_commit    (hdr_commit),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .rx_status     (rx_status),
    .rx_done       (rx_done)
  );
endmodule

// File: rtl/rx_ring_writer_chk.sv
`timescale 1ns/1ps
module rx_ring_writer_chk
  import rxr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              st_idle,
  input logic              frm_start,
  input logic              rx_halt,
  input logic              ring_full,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PG_W-1:0]   page_start,
  input logic [PG_W-1:0]   page_stop,
  input logic              rx_done,
  input logic [PG_W-1:0]   cur_page,
  input logic [PG_W-1:0]   next_q
);
  AST_HALT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && frm_start && rx_halt) |=> (!busy && !mem_we)); // R1
  AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && frm_start && ring_full) |=> (!busy && !mem_we)); // R2
  AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= {page_start, 8'h00} && mem_addr < {page_stop, 8'h00})); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R12
  AST_CUR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (cur_page == $past(next_q))); // R12
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_done); // R13
endmodule

bind rx_ring_writer rx_ring_writer_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_idle    (st_idle),
  .frm_start  (frm_start),
  .rx_halt    (rx_halt),
  .ring_full  (ring_full),
  .busy       (busy),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .page_start (page_start),
  .page_stop  (page_stop),
  .rx_done    (rx_done),
  .cur_page   (cur_page),
  .next_q     (next_q)
);

// File: tb/test_rx_ring_writer.sv
`timescale 1ns/1ps
module test_rx_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_halt = 1'b0;
  logic [7:0]  rx_cfg = 8'h00;
  logic [47:0] station_addr = 48'h665544332210;
  logic [63:0] mcast_table = 64'h0000_0000_0000_2000;
  logic [7:0]  page_start = 8'h40, page_stop = 8'h80, page_bound = 8'h40;
  logic        cur_load = 1'b0;
  logic [7:0]  cur_load_page = 8'h00;
  logic        frm_start = 1'b0;
  logic [10:0] frm_len = '0;
  logic [31:0] frm_crc = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, busy, mem_we, rx_done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page, rx_status;

  always #2 clk = ~clk;

  rx_ring_writer i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .rx_halt(rx_halt), .rx_cfg(rx_cfg),
    .station_addr(station_addr), .mcast_table(mcast_table),
    .page_start(page_start), .page_stop(page_stop), .page_bound(page_bound),
    .cur_load(cur_load), .cur_load_page(cur_load_page),
    .frm_start(frm_start), .frm_len(frm_len), .frm_crc(frm_crc),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .rx_status(rx_status), .rx_done(rx_done)
  );

  int checks = 0;
  int errors = 0;
  logic [47:0] tb_dst;
  logic [15:0] cap_addr [2048];
  logic [7:0]  cap_data [2048];
  int cap_n = 0;
  int done_n = 0;

  // sampled late in the low phase, after the driver has settled
  always @(negedge clk) begin
    #1.5;
    if (mem_we && cap_n < 2048) begin
      cap_addr[cap_n] = mem_addr;
      cap_data[cap_n] = mem_wdata;
      cap_n++;
    end
    if (rx_done) done_n++;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k);
    if (k < 6) return tb_dst[8*k +: 8];
    return 8'((k * 7 + 3) & 255);
  endfunction

  task automatic load_cur(input logic [7:0] pg);
    @(negedge clk);
    cur_load = 1'b1; cur_load_page = pg;
    @(negedge clk);
    cur_load = 1'b0;
  endtask

  task automatic send(input int len, input logic [31:0] crc, output logic busy_seen);
    @(negedge clk);
    cap_n = 0; done_n = 0;
    frm_start = 1'b1; frm_len = 11'(len); frm_crc = crc;
    @(negedge clk);
    frm_start = 1'b0;
    busy_seen = busy;
    begin
      int k = 0;
      while (k < len) begin
        in_valid = 1'b1;
        in_data  = fbyte(k);
        #1;
        if (in_ready) k++;
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  // full independent check of one frame against the requirement model
  task automatic run_frame(input int len, input logic [31:0] crc, input logic exp_acc,
                           input string ftag);
    logic bs;
    int base, plen, total, pages, nxt, bad, st_exp;
    base = int'(cur_page);
    send(len, crc, bs);
    if (!exp_acc) begin
      chk(cap_n == 0, ftag, "refused frame writes", cap_n, 0);
      chk(done_n == 0 && int'(cur_page) == base, ftag, "refused frame done/cur",
          int'(cur_page), base);
      return;
    end
    plen   = (len < 60) ? 60 : len;
    total  = plen + 4;
    pages  = (total + 4) / 256 + (((total + 4) % 256) != 0 ? 1 : 0);
    nxt    = base + pages;
    if (nxt >= int'(page_stop)) nxt = nxt - (int'(page_stop) - int'(page_start));
    st_exp = tb_dst[0] ? 8'h21 : 8'h01;
    chk(bs == 1'b1, "R13", "busy after start", int'(bs), 1);
    chk(cap_n == plen + 4, "R8", "write count", cap_n, plen + 4);
    chk(cap_addr[0] == 16'(base * 256) && cap_data[0] == 8'(st_exp), "R11",
        "status byte", int'(cap_data[0]), st_exp);
    chk(cap_data[1] == 8'(nxt), "R9", "next page byte", int'(cap_data[1]), nxt);
    chk(cap_data[2] == 8'(total) && cap_data[3] == 8'(total >> 8), "R7",
        "length bytes", int'({cap_data[3], cap_data[2]}), total);
    bad = 0;
    for (int k = 0; k < plen && k + 4 < cap_n; k++) begin
      int a;
      logic [7:0] v;
      a = base * 256 + 4 + k;
      if (a >= int'(page_stop) * 256) a = a - (int'(page_stop) - int'(page_start)) * 256;
      v = (k < len) ? fbyte(k) : 8'h00;
      if (cap_addr[k + 4] != 16'(a) || cap_data[k + 4] != v) bad++;
    end
    chk(bad == 0, "R10", "data bytes misplaced", bad, 0);
    chk(done_n == 1 && int'(cur_page) == nxt, "R12", "done/cur page",
        int'(cur_page), nxt);
    chk(int'(rx_status) == st_exp, "R11", "rx_status", int'(rx_status), st_exp);
    chk(busy == 1'b0, "R13", "busy after frame", int'(busy), 0);
  endtask

  // {cfg, kind(0 uni ok,1 uni miss,2 bcast,3 mcast), hash, len, accept}
  localparam logic [27:0] VECS [13] = '{
    {8'h00, 2'd0, 6'd0,  11'd100, 1'b1},
    {8'h00, 2'd1, 6'd0,  11'd100, 1'b0},
    {8'h10, 2'd1, 6'd0,  11'd64,  1'b1},
    {8'h00, 2'd2, 6'd0,  11'd64,  1'b0},
    {8'h04, 2'd2, 6'd0,  11'd64,  1'b1},
    {8'h04, 2'd3, 6'd13, 11'd64,  1'b0},
    {8'h08, 2'd3, 6'd13, 11'd64,  1'b1},
    {8'h08, 2'd3, 6'd14, 11'd64,  1'b0},
    {8'h00, 2'd0, 6'd0,  11'd20,  1'b1},
    {8'h08, 2'd2, 6'd0,  11'd64,  1'b0},
    {8'h00, 2'd0, 6'd0,  11'd248, 1'b1},
    {8'h00, 2'd0, 6'd0,  11'd249, 1'b1},
    {8'h1C, 2'd3, 6'd14, 11'd70,  1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic bs;
    repeat (3) @(negedge clk);
    chk(cur_page == 8'h00 && rx_status == 8'h00, "R12", "reset page/status",
        int'(cur_page), 0);
    chk(!busy && !mem_we && !rx_done && !in_ready, "R13", "reset outputs",
        int'({busy, mem_we, rx_done, in_ready}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R14: current page load
    load_cur(8'h55);
    chk(cur_page == 8'h55, "R14", "cur_load", int'(cur_page), 8'h55);

    for (int i = 0; i < 13; i++) begin
      logic [7:0] cfg;
      logic [1:0] kind;
      logic [5:0] hsh;
      int len;
      string tag;
      cfg  = VECS[i][27:20];
      kind = VECS[i][19:18];
      hsh  = VECS[i][17:12];
      len  = int'(VECS[i][11:1]);
      case (kind)
        2'd0: tb_dst = station_addr;
        2'd1: tb_dst = station_addr ^ 48'h800000000000;
        2'd2: tb_dst = 48'hFFFFFFFFFFFF;
        default: tb_dst = 48'h5E4D3C2B1A01;
      endcase
      if (cfg[4])          tag = "R3";
      else if (kind == 2)  tag = "R4";
      else if (kind == 3)  tag = "R5";
      else                 tag = "R6";
      rx_cfg = cfg;
      page_bound = 8'h40;
      load_cur(8'h40);
      run_frame(len, {hsh, 26'h1555555}, VECS[i][0], tag);
    end

    // R1: halted controller
    rx_cfg = 8'h00; tb_dst = station_addr; rx_halt = 1'b1;
    load_cur(8'h40);
    send(80, 32'h0, bs);
    chk(cap_n == 0 && done_n == 0 && bs == 1'b0, "R1", "halted frame",
        cap_n + done_n, 0);
    rx_halt = 1'b0;

    // R2: stop not above start
    page_stop = 8'h40;
    send(80, 32'h0, bs);
    chk(cap_n == 0 && done_n == 0 && bs == 1'b0, "R2", "empty ring",
        cap_n + done_n, 0);
    page_stop = 8'h80;

    // R2: free 1280 refused, free 1536 accepted
    load_cur(8'h45); page_bound = 8'h4A;
    send(80, 32'h0, bs);
    chk(cap_n == 0 && done_n == 0, "R2", "free 1280 bytes", cap_n, 0);
    page_bound = 8'h4B;
    run_frame(1514, 32'h0, 1'b1, "R2");
    chk(cur_page == 8'h4B, "R2", "max frame fills gap", int'(cur_page), 8'h4B);

    // R2: current above boundary, free 256
    load_cur(8'h7F); page_bound = 8'h40;
    send(80, 32'h0, bs);
    chk(cap_n == 0 && done_n == 0, "R2", "cur above bound", cap_n, 0);

    // R10/R9: data wrap at stop page
    page_bound = 8'h7F;
    load_cur(8'h7F);
    run_frame(300, 32'h0, 1'b1, "R10");
    chk(cap_addr[4 + 252] == 16'h4000, "R10", "wrap address",
        int'(cap_addr[4 + 252]), 16'h4000);
    chk(cur_page == 8'h41, "R9", "next page after wrap", int'(cur_page), 8'h41);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule